// File: doc/BRIEF.md
# Pulse-Swallow Synthesizer Divider

This block holds the digital dividers of a frequency synthesizer. The reference path takes the crystal clock (6.144 MHz or 12.288 MHz) and divides it by 6 or 12 to give a 1.024 MHz comparison pulse. The feedback path takes the oscillator clock and divides it by N = 32·M + A. It does this with a 32/33 dual-modulus prescaler, a main counter that holds M, and a swallow counter that holds A. The oscillator runs at twice the LO frequency, so each step of N moves the LO by 512 kHz. Both divided pulses go to an external phase detector.

When the receive flag is set, the block adds two counts to the programmed feedback ratio by itself. This gives the +1.024 MHz LO offset needed for the low IF. If adding the offset takes the swallow value to 32 or more, the excess moves into the main count, so the ratio stays exactly 32·M + A + 2. A combinational flag reports settings that a pulse-swallow divider cannot produce. The slot enable gates both dividers. While it is low, each divider parks at its terminal count. When the enable rises, both dividers emit their first pulse on their first enabled clock edge.

Top module: `synth_div`

## Requirements
- R1: With `ref_sel` = 0 the reference pulse repeats every 6 `ref_clk` cycles; with `ref_sel` = 1 it repeats every 12.
- R2: With `rx_mode` = 0 and a valid setting, the feedback pulse repeats every 32·`main_cnt` + `swal_cnt` `vco_clk` cycles.
- R3: With `rx_mode` = 1 the feedback period is 32·`main_cnt` + `swal_cnt` + 2. This holds when the offset carries into the main count, that is when `swal_cnt` + 2 ≥ 32.
- R4: `cfg_err` is 1 when any of these holds: the effective swallow value exceeds the effective main value, the effective main value is 0, or the effective main value exceeds 63. It is 0 otherwise. The effective values are taken after the offset and carry of R3.
- R5: Each output pulse is high for exactly one cycle of its own input clock.
- R6: While `pll_en` is low, neither `ref_pulse` nor `fb_pulse` is ever high.
- R7: After `pll_en` rises, each output is high in the cycle that follows the first rising edge of its clock that samples `pll_en` high. One full period later, it pulses again.
- R8: A divider samples its ratio and offset only at the edge that emits its pulse. A setting change in mid-period therefore first affects the next period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Crystal reference clock |
| vco_clk | input | 1 | Oscillator clock feeding the prescaler |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| pll_en | input | 1 | Slot enable; both dividers run while high |
| ref_sel | input | 1 | Reference ratio select: 0 gives ÷6, 1 gives ÷12 |
| rx_mode | input | 1 | Receive flag; adds the +2 count offset |
| main_cnt | input | 6 | Programmed main count M |
| swal_cnt | input | 6 | Programmed swallow count A |
| ref_pulse | output | 1 | Divided reference pulse |
| fb_pulse | output | 1 | Divided feedback pulse |
| cfg_err | output | 1 | Unreachable-ratio flag |

## Verification
Two events can land on the same oscillator edge: the end-of-period reload and the receive-offset carry. The carry changes both counts that the reload loads. The bench provokes this by sweeping swallow values 30 and 31 in receive mode. For each case it checks that the measured period equals 32·M + A + 2. The enable release and the terminal count can also coincide, since each divider is parked at its terminal count. The bench judges this by requiring both outputs to pulse on the first enabled edge and then run a full period. A mid-period setting change is also placed near a pulse boundary, to show that the old ratio finishes first.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

    // Counter width of the main and swallow counters
    localparam int CNT_W   = 6;
    // Base modulus of the dual-modulus prescaler (divides by PRE_DIV or PRE_DIV+1)
    localparam int PRE_DIV = 32;
    // Feedback counts added in receive mode
    localparam int RX_OFS  = 2;
    // Reference divider ratios selected by ref_sel
    localparam int REF_LO  = 6;
    localparam int REF_HI  = 12;

    // Effective feedback setting after offset and carry
    typedef struct packed {
        logic [CNT_W:0]   main;
        logic [CNT_W-1:0] swal;
        logic             err;
    } fb_cfg_t;

endpackage

// File: rtl/sd_cfg.sv
module sd_cfg
    import synth_div_pkg::*;
(
    input  logic [CNT_W-1:0] main_i,
    input  logic [CNT_W-1:0] swal_i,
    input  logic             rx_i,
    output fb_cfg_t          cfg_o
);

    localparam int            SW   = CNT_W + 1;
    localparam logic [SW-1:0] OFS  = SW'(RX_OFS);
    localparam logic [SW-1:0] PRE  = SW'(PRE_DIV);
    localparam logic [SW-1:0] MAXM = SW'((1 << CNT_W) - 1);

    logic [SW-1:0] swal_sum;
    logic [SW-1:0] swal_eff;
    logic [SW-1:0] main_eff;
    logic          carry;

    always_comb begin
        swal_sum = {1'b0, swal_i} + (rx_i ? OFS : '0);
        // Offset pushing the swallow value past the prescaler modulus moves
        // one prescaler period into the main count (R3)
        carry    = rx_i && (swal_sum >= PRE);
        swal_eff = carry ? (swal_sum - PRE) : swal_sum;
        main_eff = {1'b0, main_i} + (carry ? SW'(1) : SW'(0));

        cfg_o.main = main_eff;
        cfg_o.swal = swal_eff[CNT_W-1:0];
        cfg_o.err  = (swal_eff > main_eff) || (main_eff == '0) || (main_eff > MAXM);
    end

endmodule

// File: rtl/sd_ref_div.sv
module sd_ref_div
    import synth_div_pkg::*;
(
    input  logic ref_clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic sel_i,
    output logic pulse_o
);

    localparam int RW = $clog2(REF_HI);

    typedef struct packed {
        logic [RW-1:0] cnt;
        logic          pulse;
    } ref_st_t;

    ref_st_t st_d, st_q;
    logic [RW-1:0] reload;

    always_comb begin
        reload = sel_i ? RW'(REF_HI - 1) : RW'(REF_LO - 1);
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (!en_i) begin
            st_d.cnt = '0;                 // park at terminal count
        end else if (st_q.cnt == '0) begin
            st_d.cnt   = reload;           // ratio sampled only here (R8)
            st_d.pulse = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;

endmodule

// File: rtl/sd_prescaler.sv
module sd_prescaler
    import synth_div_pkg::*;
(
    input  logic vco_clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic mod_hi_i,
    output logic tick_o
);

    localparam int            PW      = $clog2(PRE_DIV + 1);
    localparam logic [PW-1:0] LAST_LO = PW'(PRE_DIV - 1);
    localparam logic [PW-1:0] LAST_HI = PW'(PRE_DIV);

    logic [PW-1:0] cnt_d, cnt_q;
    logic          tick;

    always_comb begin
        tick = en_i && (cnt_q == (mod_hi_i ? LAST_HI : LAST_LO));
        if (!en_i) begin
            cnt_d = LAST_LO;               // parked so the first enabled edge ticks
        end else if (tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge vco_clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= LAST_LO;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick_o = tick;

endmodule

// File: rtl/sd_fb_div.sv
module sd_fb_div
    import synth_div_pkg::*;
(
    input  logic             vco_clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W:0]   main_i,
    input  logic [CNT_W-1:0] swal_i,
    output logic             pulse_o
);

    localparam logic [CNT_W:0] ONE = (CNT_W + 1)'(1);

    typedef struct packed {
        logic [CNT_W:0]   main;
        logic [CNT_W-1:0] swal;
        logic             pulse;
    } fb_st_t;

    fb_st_t st_d, st_q;
    logic   tick;
    logic   mod_hi;

    // Prescaler divides by PRE_DIV+1 while swallow counts remain
    assign mod_hi = (st_q.swal != '0);

    sd_prescaler i_pre (
        .vco_clk  (vco_clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .mod_hi_i (mod_hi),
        .tick_o   (tick)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (!en_i) begin
            st_d.main = ONE;               // parked at terminal count
            st_d.swal = '0;
        end else if (tick) begin
            if (st_q.main <= ONE) begin
                st_d.main  = main_i;       // setting sampled only here (R8)
                st_d.swal  = swal_i;
                st_d.pulse = 1'b1;
            end else begin
                st_d.main = st_q.main - 1'b1;
                if (st_q.swal != '0) begin
                    st_d.swal = st_q.swal - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge vco_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.main  <= ONE;
            st_q.swal  <= '0;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;

endmodule

// File: rtl/synth_div.sv
module synth_div
    import synth_div_pkg::*;
(
    input  logic             ref_clk,
    input  logic             vco_clk,
    input  logic             rst_n,
    input  logic             pll_en,
    input  logic             ref_sel,
    input  logic             rx_mode,
    input  logic [CNT_W-1:0] main_cnt,
    input  logic [CNT_W-1:0] swal_cnt,
    output logic             ref_pulse,
    output logic             fb_pulse,
    output logic             cfg_err
);

    fb_cfg_t cfg;

    sd_cfg i_cfg (
        .main_i (main_cnt),
        .swal_i (swal_cnt),
        .rx_i   (rx_mode),
        .cfg_o  (cfg)
    );

    sd_ref_div i_ref (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .en_i    (pll_en),
        .sel_i   (ref_sel),
        .pulse_o (ref_pulse)
    );

    sd_fb_div i_fb (
        .vco_clk (vco_clk),
        .rst_n   (rst_n),
        .en_i    (pll_en),
        .main_i  (cfg.main),
        .swal_i  (cfg.swal),
        .pulse_o (fb_pulse)
    );

    assign cfg_err = cfg.err;

endmodule

// File: rtl/synth_div_chk.sv
module synth_div_chk
    import synth_div_pkg::*;
(
    input logic             ref_clk,
    input logic             vco_clk,
    input logic             rst_n,
    input logic             pll_en,
    input logic             ref_sel,
    input logic             rx_mode,
    input logic [CNT_W-1:0] main_cnt,
    input logic [CNT_W-1:0] swal_cnt,
    input logic             ref_pulse,
    input logic             fb_pulse,
    input logic             cfg_err
);

    int   ref_n_q, ref_exp_q, fb_n_q, fb_exp_q;
    logic ref_ok_q, fb_ok_q;

    // Cycle counters between pulses; valid only across an unbroken enable
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_n_q <= 0; ref_exp_q <= 0; ref_ok_q <= 1'b0;
        end else if (!pll_en) begin
            ref_ok_q <= 1'b0;
        end else if (ref_pulse) begin
            ref_ok_q  <= 1'b1;
            ref_n_q   <= 1;
            ref_exp_q <= ref_sel ? REF_HI : REF_LO;
        end else begin
            ref_n_q <= ref_n_q + 1;
        end
    end

    always_ff @(posedge vco_clk or negedge rst_n) begin
        if (!rst_n) begin
            fb_n_q <= 0; fb_exp_q <= 0; fb_ok_q <= 1'b0;
        end else if (!pll_en) begin
            fb_ok_q <= 1'b0;
        end else if (fb_pulse) begin
            fb_ok_q  <= !cfg_err;
            fb_n_q   <= 1;
            fb_exp_q <= PRE_DIV * int'(main_cnt) + int'(swal_cnt) + (rx_mode ? RX_OFS : 0);
        end else begin
            fb_n_q <= fb_n_q + 1;
        end
    end

    p_ref_period_r1: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (ref_pulse && ref_ok_q) |-> (ref_n_q == ref_exp_q));

    // Covers R2 and R3 (offset included in the expected count) and R8
    p_fb_period_r2: assert property (@(posedge vco_clk) disable iff (!rst_n)
        (fb_pulse && fb_ok_q) |-> (fb_n_q == fb_exp_q));

    p_ref_width_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ref_pulse |=> !ref_pulse);

    p_fb_width_r5: assert property (@(posedge vco_clk) disable iff (!rst_n)
        fb_pulse |=> !fb_pulse);

    p_ref_gate_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !pll_en |=> !ref_pulse);

    p_fb_gate_r6: assert property (@(posedge vco_clk) disable iff (!rst_n)
        !pll_en |=> !fb_pulse);

    p_ref_first_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(pll_en) |=> ref_pulse);

    p_fb_first_r7: assert property (@(posedge vco_clk) disable iff (!rst_n)
        $rose(pll_en) |=> fb_pulse);

endmodule

bind synth_div synth_div_chk i_chk (
    .ref_clk   (ref_clk),
    .vco_clk   (vco_clk),
    .rst_n     (rst_n),
    .pll_en    (pll_en),
    .ref_sel   (ref_sel),
    .rx_mode   (rx_mode),
    .main_cnt  (main_cnt),
    .swal_cnt  (swal_cnt),
    .ref_pulse (ref_pulse),
    .fb_pulse  (fb_pulse),
    .cfg_err   (cfg_err)
);

// File: tb/test_synth_div.sv
module test_synth_div;

    localparam int CLK_PERIOD = 2;     // oscillator clock
    localparam int REF_PERIOD = 12;    // reference clock
    localparam int WATCHDOG   = 300000;

    logic       ref_clk, vco_clk, rst_n, pll_en, ref_sel, rx_mode;
    logic [5:0] main_cnt, swal_cnt;
    logic       ref_pulse, fb_pulse, cfg_err;

    int checks = 0;
    int fails  = 0;
    int vcyc   = 0;
    int rcyc   = 0;

    synth_div i_synth_div (
        .ref_clk   (ref_clk),
        .vco_clk   (vco_clk),
        .rst_n     (rst_n),
        .pll_en    (pll_en),
        .ref_sel   (ref_sel),
        .rx_mode   (rx_mode),
        .main_cnt  (main_cnt),
        .swal_cnt  (swal_cnt),
        .ref_pulse (ref_pulse),
        .fb_pulse  (fb_pulse),
        .cfg_err   (cfg_err)
    );

    initial begin
        vco_clk = 1'b0;
        forever #(CLK_PERIOD / 2) vco_clk = ~vco_clk;
    end

    // Reference edges fall on odd times, away from the even input-change times
    initial begin
        ref_clk = 1'b0;
        #3;
        forever #(REF_PERIOD / 2) ref_clk = ~ref_clk;
    end

    always @(posedge vco_clk) vcyc <= vcyc + 1;
    always @(posedge ref_clk) rcyc <= rcyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic next_fb(output int t);
        t = -1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge vco_clk);
            if (fb_pulse) begin
                t = vcyc;
                break;
            end
        end
    endtask

    task automatic next_ref(output int t);
        t = -1;
        for (int i = 0; i < 100; i++) begin
            @(negedge ref_clk);
            if (ref_pulse) begin
                t = rcyc;
                break;
            end
        end
    endtask

    function automatic bit exp_err(input int m, input int a, input bit rx);
        int em, ea;
        if (rx && (a + 2 >= 32)) begin
            ea = a + 2 - 32; em = m + 1;
        end else begin
            ea = a + (rx ? 2 : 0); em = m;
        end
        return (ea > em) || (em == 0) || (em > 63);
    endfunction

    initial begin
        int t1, t2, t3, c0, n, seen;
        int mlist [6] = '{2, 3, 16, 31, 40, 63};
        int alist [5];

        rst_n = 1'b0; pll_en = 1'b0; ref_sel = 1'b0; rx_mode = 1'b0;
        main_cnt = 6'd2; swal_cnt = 6'd0;
        repeat (4) @(negedge vco_clk);
        check(!ref_pulse && !fb_pulse, "R6 reset state", int'({ref_pulse, fb_pulse}), 0);
        rst_n = 1'b1;

        // R6: no pulses while the enable is low
        seen = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge vco_clk);
            if (ref_pulse || fb_pulse) seen++;
        end
        check(seen == 0, "R6 gated outputs", seen, 0);

        // R1 and R7 on the reference divider, both ratios
        for (int s = 0; s < 2; s++) begin
            @(negedge vco_clk);
            pll_en = 1'b0;
            repeat (30) @(negedge vco_clk);
            ref_sel = s[0];
            c0 = rcyc;
            pll_en = 1'b1;
            next_ref(t1);
            check(t1 == c0 + 1, "R7 first reference pulse", t1, c0 + 1);
            next_ref(t2);
            check(t2 - t1 == (s ? 12 : 6), "R1 reference period", t2 - t1, s ? 12 : 6);
            next_ref(t3);
            check(t3 - t2 == (s ? 12 : 6), "R1 reference period repeat", t3 - t2, s ? 12 : 6);
        end

        // R2, R3, R4, R7: sweep of feedback settings in both modes
        for (int rx = 0; rx < 2; rx++) begin
            for (int mi = 0; mi < 6; mi++) begin
                alist = '{0, 1, mlist[mi], 30, 31};
                for (int ai = 0; ai < 5; ai++) begin
                    @(negedge vco_clk);
                    pll_en   = 1'b0;
                    rx_mode  = rx[0];
                    main_cnt = 6'(mlist[mi]);
                    swal_cnt = 6'(alist[ai]);
                    repeat (2) @(negedge vco_clk);
                    check(cfg_err == exp_err(mlist[mi], alist[ai], rx[0]), "R4 config flag",
                          int'(cfg_err), int'(exp_err(mlist[mi], alist[ai], rx[0])));
                    if (!exp_err(mlist[mi], alist[ai], rx[0])) begin
                        n  = 32 * mlist[mi] + alist[ai] + (rx ? 2 : 0);
                        c0 = vcyc;
                        pll_en = 1'b1;
                        next_fb(t1);
                        check(t1 == c0 + 1, "R7 first feedback pulse", t1, c0 + 1);
                        next_fb(t2);
                        check(t2 - t1 == n, rx ? "R3 receive period" : "R2 transmit period",
                              t2 - t1, n);
                    end
                end
            end
        end

        // R4 corner values
        @(negedge vco_clk);
        pll_en = 1'b0; rx_mode = 1'b0; main_cnt = 6'd0; swal_cnt = 6'd0;
        #1 check(cfg_err == 1'b1, "R4 zero main count", int'(cfg_err), 1);
        rx_mode = 1'b1; main_cnt = 6'd5; swal_cnt = 6'd5;
        #1 check(cfg_err == 1'b1, "R4 offset exceeds main", int'(cfg_err), 1);
        rx_mode = 1'b0;
        #1 check(cfg_err == 1'b0, "R4 equal counts legal", int'(cfg_err), 0);

        // R8: change the setting in mid-period
        @(negedge vco_clk);
        rx_mode = 1'b0; main_cnt = 6'd3; swal_cnt = 6'd1;
        repeat (2) @(negedge vco_clk);
        pll_en = 1'b1;
        next_fb(t1);
        repeat (5) @(negedge vco_clk);
        main_cnt = 6'd4; swal_cnt = 6'd2;
        next_fb(t2);
        check(t2 - t1 == 97, "R8 old ratio completes", t2 - t1, 97);
        next_fb(t3);
        check(t3 - t2 == 130, "R8 new ratio follows", t3 - t2, 130);

        // R5: pulse width on both outputs
        @(negedge vco_clk);
        check(fb_pulse == 1'b0, "R5 feedback pulse width", int'(fb_pulse), 0);
        next_ref(t1);
        @(negedge ref_clk);
        check(ref_pulse == 1'b0, "R5 reference pulse width", int'(ref_pulse), 0);

        @(negedge vco_clk);
        pll_en = 1'b0;
        repeat (4) @(negedge vco_clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(WATCHDOG);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule